// File: doc/BRIEF.md
# Interrupt Status Bank with Per-Source Read-to-Clear

This block collects the interrupt events of a serial bus controller into one register-mapped bank. Ten sources arrive as single-cycle pulses and are held in a latched raw status until software clears them. Two sources reflect FIFO conditions and simply track level inputs. A software-writable enable mask is applied to the raw status to form a masked view. The single interrupt line is the registered OR of the masked bits.

Software sees the bank through a synchronous register port. Reading an address can clear state. Each latched source has its own read-to-clear address, which removes only that bit. A combined read-to-clear address removes every latched bit at once. Any event that is latched between software reading the status and issuing the combined clear is lost. Drivers that must not lose events therefore use the per-source addresses.

Top module: `irq_status_bank`

## Requirements
- R1: Status bit order is fixed: 0 receive underflow, 1 receive overflow, 2 receive full, 3 transmit overflow, 4 transmit empty, 5 read request, 6 transmit abort, 7 receive done, 8 activity, 9 stop seen, 10 start seen, 11 general call. A one-cycle pulse on `evt_i[n]` (n not 2 or 4) sets raw bit n, and the bit stays set until it is cleared. `evt_i[2]` and `evt_i[4]` have no effect. The raw status reads at offset 0x34 in bits 11:0.
- R2: Offset 0x30 is the mask register, read/write in bits 11:0. Offset 0x2C always reads raw status AND mask.
- R3: A read of offset 0x40 clears every latched bit (all bits except 2 and 4) on the same edge. It returns in bit 0 the OR of the latched bits just before the clear.
- R4: Reading a per-source clear address clears only its bit and returns the previous value of that bit in bit 0, with all other bits zero. The addresses are 0x44 + 4·k, where k counts the latched bits in ascending order: 0x44 bit 0, 0x48 bit 1, 0x4C bit 3, 0x50 bit 5, 0x54 bit 6, 0x58 bit 7, 0x5C bit 8, 0x60 bit 9, 0x64 bit 10, 0x68 bit 11.
- R5: Raw bit 2 equals `rx_full_i` and raw bit 4 equals `tx_empty_i`. No clear read affects them.
- R6: When an event pulse and a clear read (combined or per-source) hit the same bit in one cycle, the bit remains set.
- R7: After reset, the latched bits are zero, the mask is 0xFFF and `irq_o` is low.
- R8: `irq_o` is a register that holds the OR of the masked status as of the previous edge. It falls on the same edge that clears or masks off the last active bit.
- R9: Reads of any other address return zero and change nothing. Writes to any address other than 0x30 change nothing.
- R10: Read data appears on `reg_rdata_o` in the cycle after the read strobe. In cycles that follow no read, `reg_rdata_o` is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| evt_i | input | 12 | One-cycle event pulses, one per status bit |
| rx_full_i | input | 1 | Receive FIFO full level |
| tx_empty_i | input | 1 | Transmit FIFO empty level |
| reg_en_i | input | 1 | Register access strobe |
| reg_we_i | input | 1 | 1 = write, 0 = read |
| reg_addr_i | input | 8 | Byte address of the register |
| reg_wdata_i | input | 32 | Write data |
| reg_rdata_o | output | 32 | Registered read data |
| irq_o | output | 1 | Interrupt request |

## Verification
The bench builds the bank with its default 8-bit address and 32-bit data widths. With these widths the full offset map can be reached, up to the last per-source clear address at 0x68. Unmapped offsets between the status words and the clear range can also be probed.

The bench exercises the following cases:
- each of the ten per-source clears in turn, against a fully set bank;
- both level sources held high across a combined clear;
- a pulse that lands in the same cycle as a combined clear;
- a pulse that lands in the same cycle as a per-source clear.

// File: rtl/irq_bank_pkg.sv
package irq_bank_pkg;

    localparam int NUM_SRC = 12;

    localparam int SRC_RX_FULL  = 2;
    localparam int SRC_TX_EMPTY = 4;

    localparam logic [NUM_SRC-1:0] LEVEL_SRC =
        (NUM_SRC'(1) << SRC_RX_FULL) | (NUM_SRC'(1) << SRC_TX_EMPTY);
    localparam logic [NUM_SRC-1:0] LATCH_SRC = ~LEVEL_SRC;

    localparam int OFS_MASKED   = 'h2C;
    localparam int OFS_MASK     = 'h30;
    localparam int OFS_RAW      = 'h34;
    localparam int OFS_CLR_ALL  = 'h40;
    localparam int OFS_CLR_BASE = 'h44;
    localparam int CLR_STRIDE   = 4;

    // Position of a latched source among the latched sources, in ascending order.
    function automatic int clr_slot(input int src);
        int n;
        n = 0;
        for (int k = 0; k < src; k++) begin
            if (LATCH_SRC[k]) n++;
        end
        return n;
    endfunction

endpackage

// File: rtl/irq_addr_decode.sv
module irq_addr_decode
    import irq_bank_pkg::*;
#(
    parameter int ADDR_W = 8
) (
    input  logic               en_i,
    input  logic               we_i,
    input  logic [ADDR_W-1:0]  addr_i,
    output logic               rd_masked_o,
    output logic               rd_mask_o,
    output logic               rd_raw_o,
    output logic               wr_mask_o,
    output logic               clr_all_o,
    output logic [NUM_SRC-1:0] clr_one_o
);

    logic rd;
    assign rd = en_i & ~we_i;

    assign rd_masked_o = rd && (addr_i == ADDR_W'(OFS_MASKED));
    assign rd_mask_o   = rd && (addr_i == ADDR_W'(OFS_MASK));
    assign rd_raw_o    = rd && (addr_i == ADDR_W'(OFS_RAW));
    assign clr_all_o   = rd && (addr_i == ADDR_W'(OFS_CLR_ALL));
    assign wr_mask_o   = en_i && we_i && (addr_i == ADDR_W'(OFS_MASK));

    for (genvar i = 0; i < NUM_SRC; i++) begin : g_clr
        if (LATCH_SRC[i]) begin : g_latched
            localparam int SLOT = clr_slot(i);
            localparam int CLR_ADDR = OFS_CLR_BASE + CLR_STRIDE * SLOT;
            assign clr_one_o[i] = rd && (addr_i == ADDR_W'(CLR_ADDR));
        end else begin : g_level
            assign clr_one_o[i] = 1'b0;
        end
    end

endmodule

// File: rtl/irq_src_cell.sv
module irq_src_cell (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic evt_i,
    input  logic clr_i,
    output logic bit_o,
    output logic next_o
);

    logic latched_d, latched_q;

    // A new event overrides a clear in the same cycle.
    always_comb begin
        latched_d = evt_i | (latched_q & ~clr_i);
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) latched_q <= 1'b0;
        else         latched_q <= latched_d;
    end

    assign bit_o  = latched_q;
    assign next_o = latched_d;

endmodule

// File: rtl/irq_read_mux.sv
module irq_read_mux
    import irq_bank_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic               rd_masked_i,
    input  logic               rd_mask_i,
    input  logic               rd_raw_i,
    input  logic               clr_all_i,
    input  logic [NUM_SRC-1:0] clr_one_i,
    input  logic [NUM_SRC-1:0] raw_i,
    input  logic [NUM_SRC-1:0] mask_i,
    output logic [DATA_W-1:0]  rdata_o
);

    always_comb begin
        rdata_o = '0;
        if (rd_raw_i) begin
            rdata_o = DATA_W'(raw_i);
        end else if (rd_mask_i) begin
            rdata_o = DATA_W'(mask_i);
        end else if (rd_masked_i) begin
            rdata_o = DATA_W'(raw_i & mask_i);
        end else if (clr_all_i) begin
            rdata_o = DATA_W'(|(raw_i & LATCH_SRC));
        end else if (|clr_one_i) begin
            rdata_o = DATA_W'(|(raw_i & clr_one_i));
        end
    end

endmodule

// File: rtl/irq_status_bank.sv
module irq_status_bank
    import irq_bank_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 32
) (
    input  logic               clk_i,
    input  logic               rst_ni,
    input  logic [NUM_SRC-1:0] evt_i,
    input  logic               rx_full_i,
    input  logic               tx_empty_i,
    input  logic               reg_en_i,
    input  logic               reg_we_i,
    input  logic [ADDR_W-1:0]  reg_addr_i,
    input  logic [DATA_W-1:0]  reg_wdata_i,
    output logic [DATA_W-1:0]  reg_rdata_o,
    output logic               irq_o
);

    typedef struct packed {
        logic [NUM_SRC-1:0] mask;
        logic               irq;
        logic [DATA_W-1:0]  rdata;
    } bank_state_t;

    bank_state_t state_d, state_q;

    logic               rd_masked, rd_mask, rd_raw, wr_mask, clr_all;
    logic [NUM_SRC-1:0] clr_one;
    logic [NUM_SRC-1:0] raw_view;
    logic [NUM_SRC-1:0] raw_next;
    logic [DATA_W-1:0]  rdata_mux;

    logic unused_inputs;
    assign unused_inputs = ^(evt_i & LEVEL_SRC) ^ ^reg_wdata_i[DATA_W-1:NUM_SRC];

    irq_addr_decode #(.ADDR_W(ADDR_W)) u_decode (
        .en_i        (reg_en_i),
        .we_i        (reg_we_i),
        .addr_i      (reg_addr_i),
        .rd_masked_o (rd_masked),
        .rd_mask_o   (rd_mask),
        .rd_raw_o    (rd_raw),
        .wr_mask_o   (wr_mask),
        .clr_all_o   (clr_all),
        .clr_one_o   (clr_one)
    );

    for (genvar i = 0; i < NUM_SRC; i++) begin : g_src
        if (i == SRC_RX_FULL) begin : g_rx_full
            assign raw_view[i] = rx_full_i;
            assign raw_next[i] = rx_full_i;
        end else if (i == SRC_TX_EMPTY) begin : g_tx_empty
            assign raw_view[i] = tx_empty_i;
            assign raw_next[i] = tx_empty_i;
        end else begin : g_latched
            irq_src_cell u_cell (
                .clk_i  (clk_i),
                .rst_ni (rst_ni),
                .evt_i  (evt_i[i]),
                .clr_i  (clr_one[i] | clr_all),
                .bit_o  (raw_view[i]),
                .next_o (raw_next[i])
            );
        end
    end

    irq_read_mux #(.DATA_W(DATA_W)) u_rmux (
        .rd_masked_i (rd_masked),
        .rd_mask_i   (rd_mask),
        .rd_raw_i    (rd_raw),
        .clr_all_i   (clr_all),
        .clr_one_i   (clr_one),
        .raw_i       (raw_view),
        .mask_i      (state_q.mask),
        .rdata_o     (rdata_mux)
    );

    always_comb begin
        state_d       = state_q;
        state_d.rdata = rdata_mux;
        if (wr_mask) begin
            state_d.mask = reg_wdata_i[NUM_SRC-1:0];
        end
        state_d.irq = |(raw_next & state_d.mask);
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            state_q.mask  <= '1;
            state_q.irq   <= 1'b0;
            state_q.rdata <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    assign reg_rdata_o = state_q.rdata;
    assign irq_o       = state_q.irq;

endmodule

// File: rtl/irq_bank_checker.sv
module irq_bank_checker
    import irq_bank_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input logic               clk_i,
    input logic               rst_ni,
    input logic [NUM_SRC-1:0] evt_i,
    input logic               reg_en_i,
    input logic               reg_we_i,
    input logic               rd_masked,
    input logic               clr_all,
    input logic [NUM_SRC-1:0] clr_one,
    input logic [NUM_SRC-1:0] raw_view,
    input logic [NUM_SRC-1:0] mask_q,
    input logic [DATA_W-1:0]  reg_rdata_o,
    input logic               irq_o
);

    // R2: a masked-status read returns raw AND mask as seen at the strobe
    assert_masked_view_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $past(rst_ni) && $past(rd_masked) |->
            reg_rdata_o == DATA_W'($past(raw_view & mask_q)));

    // R3: after a combined clear, only bits newly pulsed may remain latched
    assert_clear_all_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $past(rst_ni) && $past(clr_all) |->
            ((raw_view & LATCH_SRC & ~$past(evt_i)) == '0));

    // R4: bits not targeted by a clear never drop
    assert_isolated_clear_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $past(rst_ni) && !$past(clr_all) |->
            (($past(raw_view & LATCH_SRC & ~clr_one) & ~raw_view) == '0));

    // R6: a pulse wins over a clear hitting the same bit
    assert_set_wins_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $past(rst_ni) |->
            (($past(evt_i & LATCH_SRC) & ~raw_view) == '0));

    // R8: the interrupt line tracks the masked status one edge later
    assert_irq_follows_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $past(rst_ni) |->
            irq_o == |(((raw_view & LATCH_SRC) | $past(raw_view & LEVEL_SRC)) & mask_q));

    // R10: no read strobe, no read data
    assert_idle_rdata_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $past(rst_ni) && !$past(reg_en_i && !reg_we_i) |-> reg_rdata_o == '0);

endmodule

bind irq_status_bank irq_bank_checker #(.DATA_W(DATA_W)) u_chk (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .evt_i       (evt_i),
    .reg_en_i    (reg_en_i),
    .reg_we_i    (reg_we_i),
    .rd_masked   (rd_masked),
    .clr_all     (clr_all),
    .clr_one     (clr_one),
    .raw_view    (raw_view),
    .mask_q      (state_q.mask),
    .reg_rdata_o (reg_rdata_o),
    .irq_o       (irq_o)
);

// File: tb/irq_status_bank_test.sv
module irq_status_bank_test;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [11:0] evt = '0;
    logic        rx_full = 1'b0;
    logic        tx_empty = 1'b0;
    logic        en = 1'b0;
    logic        we = 1'b0;
    logic [7:0]  addr = '0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic        irq;

    int checks = 0;
    int failures = 0;
    bit finished = 1'b0;

    logic [31:0] exp_q[$];
    string       tag_q[$];
    logic        mon_pend = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    irq_status_bank uut (
        .clk_i       (clk),
        .rst_ni      (rst_n),
        .evt_i       (evt),
        .rx_full_i   (rx_full),
        .tx_empty_i  (tx_empty),
        .reg_en_i    (en),
        .reg_we_i    (we),
        .reg_addr_i  (addr),
        .reg_wdata_i (wdata),
        .reg_rdata_o (rdata),
        .irq_o       (irq)
    );

    // Monitor: a read strobed at an edge produces data checked at the next falling edge.
    always @(posedge clk) mon_pend <= en & ~we;

    always @(negedge clk) begin
        if (mon_pend) begin
            checks++;
            if (exp_q.size() == 0) begin
                failures++;
                $display("FAIL R10: unexpected read data %h", rdata);
            end else begin
                logic [31:0] e;
                string t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                if (rdata !== e) begin
                    failures++;
                    $display("FAIL %s: rdata actual=%h expected=%h", t, rdata, e);
                end
            end
        end
    end

    task automatic check_val(input logic [31:0] act, input logic [31:0] exp, input string tag);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic pulse(input logic [11:0] m);
        @(negedge clk); evt = m;
        @(negedge clk); evt = '0;
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk); en = 1'b1; we = 1'b1; addr = a; wdata = d;
        @(negedge clk); en = 1'b0; we = 1'b0;
    endtask

    task automatic rd_evt(input logic [7:0] a, input logic [11:0] m,
                          input logic [31:0] exp, input string tag);
        @(negedge clk); en = 1'b1; we = 1'b0; addr = a; evt = m;
        exp_q.push_back(exp); tag_q.push_back(tag);
        @(negedge clk); en = 1'b0; evt = '0;
    endtask

    task automatic rd(input logic [7:0] a, input logic [31:0] exp, input string tag);
        rd_evt(a, 12'h000, exp, tag);
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        failures++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        finish_run();
    end

    initial begin
        int clr_bits[10] = '{0, 1, 3, 5, 6, 7, 8, 9, 10, 11};
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R7: reset state
        check_val({31'd0, irq}, 32'd0, "R7 irq after reset");
        rd(8'h30, 32'h0000_0FFF, "R7 mask reset");
        rd(8'h34, 32'h0, "R7 raw reset");

        // R1: pulses latch and hold; level-bit pulses ignored
        pulse(12'h041);
        pulse(12'h014);
        @(negedge clk);
        rd(8'h34, 32'h0000_0041, "R1 latched raw");
        check_val({31'd0, irq}, 32'd1, "R8 irq raised");

        // R2: mask and masked view
        wr(8'h30, 32'hFFFF_F040);
        rd(8'h30, 32'h0000_0040, "R2 mask readback");
        rd(8'h2C, 32'h0000_0040, "R2 masked view");

        // R5 / R3: level bit follows input, combined clear spares it
        rx_full = 1'b1;
        rd(8'h34, 32'h0000_0045, "R5 rx full level");
        rd(8'h40, 32'h0000_0001, "R3 combined clear return");
        check_val({31'd0, irq}, 32'd0, "R8 irq falls on clear edge");
        rd(8'h34, 32'h0000_0004, "R3 raw after combined clear");

        // R8: level source drives irq, falls one edge after input drops
        wr(8'h30, 32'h0000_0FFF);
        check_val({31'd0, irq}, 32'd1, "R8 irq from level source");
        rx_full = 1'b0;
        @(negedge clk);
        check_val({31'd0, irq}, 32'd0, "R8 irq after level drop");

        // R5: transmit empty survives a combined clear
        tx_empty = 1'b1;
        rd(8'h40, 32'h0, "R3 combined clear with nothing latched");
        rd(8'h34, 32'h0000_0010, "R5 tx empty kept");
        tx_empty = 1'b0;

        // R4: per-source clear isolation
        pulse(12'hE00);
        rd(8'h60, 32'h1, "R4 stop clear return");
        rd(8'h34, 32'h0000_0C00, "R4 only stop cleared");
        rd(8'h60, 32'h0, "R4 second stop clear");

        // R9: unmapped reads and stray writes
        rd(8'h38, 32'h0, "R9 unmapped read");
        rd(8'h6C, 32'h0, "R9 read past clear range");
        wr(8'h34, 32'h0);
        wr(8'h40, 32'h0);
        rd(8'h34, 32'h0000_0C00, "R9 raw after stray writes");

        // R6: set wins over per-source clear, and over combined clear
        rd_evt(8'h64, 12'h400, 32'h1, "R6 start clear with new pulse");
        rd(8'h34, 32'h0000_0C00, "R6 start kept after per-source clear");
        rd_evt(8'h40, 12'h001, 32'h1, "R6 combined clear with pulse");
        rd(8'h34, 32'h0000_0001, "R6 pulse survives combined clear");

        // R10: data only in the cycle after the strobe
        @(negedge clk);
        check_val(rdata, 32'h0, "R10 rdata idle");

        // R4: every per-source clear address
        pulse(12'hFFF);
        for (int k = 0; k < 10; k++) begin
            rd(8'(8'h44 + 4 * k), 32'h1, $sformatf("R4 clear bit %0d", clr_bits[k]));
        end
        rd(8'h34, 32'h0, "R4 all latched cleared");
        check_val({31'd0, irq}, 32'd0, "R8 irq after last clear");

        repeat (2) @(negedge clk);
        check_val(exp_q.size(), 32'd0, "R10 pending reads");
        finish_run();
    end

endmodule